// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor that keeps all data in one accumulator. A separate index register takes part in address formation and nowhere else. The core fetches one instruction word at a time from a unified, word-addressed, single-port synchronous memory. Every fetch follows a fixed register-transfer order through a memory address register, a memory data register and a current-instruction register. The core then executes one of eight operations:

- load, with direct, pointer-indirect or index-offset addressing
- store of the accumulator
- increment of the accumulator
- unconditional jump
- load of the index register from the operand field
- halt

A controller with one state per memory access sequences the work. Every read returns its data one cycle after it is issued. The halt flag, the accumulator and the program counter are brought out for observation. Once the core halts, it makes no further memory accesses.

Top module: `acc_core`

## Requirements
- R1: While reset is held, and until the first clock edge after it is released, the program counter and the accumulator read zero and the halt flag is low. The index register also clears to zero.
- R2: A fetch copies the program counter into the address register. It then raises the counter by one and issues a read at the address register, so the fetch address is the counter value from before the increment. It captures the returned word in the data register, then moves that word into the instruction register.
- R3: An instruction word is DATA_W bits wide. The opcode sits in the top 4 bits and the operand address in the low ADDR_W bits.
- R4: Opcode 1 loads the word at the operand address into the accumulator.
- R5: Opcode 2 writes the accumulator to the operand address in a single write cycle.
- R6: Opcode 3 reads the word at the operand address and takes its low ADDR_W bits as a second address. It then loads the word at that second address into the accumulator.
- R7: Opcode 4 loads the word at (operand + index register) mod 2^ADDR_W into the accumulator.
- R8: Opcode 5 adds one to the accumulator, wrapping modulo 2^DATA_W.
- R9: Opcode 6 sets the program counter to the operand, and the next fetch reads that address.
- R10: Opcode 8 loads the index register with the operand.
- R11: Opcode 7 and every undefined opcode (0 and 9 to 15) stop the core. The halt flag stays high, the program counter and the accumulator hold their values, and the core issues no read or write.
- R12: Each instruction takes a fixed number of cycles. Opcodes 2, 5, 6, 7 and 8 and the undefined opcodes take 5 cycles, opcodes 1 and 4 take 7, and opcode 3 takes 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata in the next cycle |
| mem_wr | output | 1 | Write strobe, taken at the rising edge |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after mem_rd |
| halted | output | 1 | High once a stop opcode has executed |
| acc_out | output | DATA_W | Accumulator value |
| pc_out | output | ADDR_W | Program counter value |

## Verification
The bench builds the core with ADDR_W = 8 and DATA_W = 12, so the whole 256-word memory fits inside the bench. At this size the indexed load can be swept over every index value, including every case where the effective address wraps past the top of memory. An increment wrap from 0xFFF to 0 takes only a few instructions to reach. Every undefined opcode in the 4-bit field can also be tried one by one, and the pointer words used for indirect loads carry nonzero upper bits, which shows that only their low address bits are used.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_LD_DIR = 4'd1;
    localparam logic [OPC_W-1:0] OPC_STORE  = 4'd2;
    localparam logic [OPC_W-1:0] OPC_LD_IND = 4'd3;
    localparam logic [OPC_W-1:0] OPC_LD_IDX = 4'd4;
    localparam logic [OPC_W-1:0] OPC_INCR   = 4'd5;
    localparam logic [OPC_W-1:0] OPC_JUMP   = 4'd6;
    localparam logic [OPC_W-1:0] OPC_STOP   = 4'd7;
    localparam logic [OPC_W-1:0] OPC_SET_IX = 4'd8;

    typedef enum logic [3:0] {
        ST_F_MAR,
        ST_F_INC,
        ST_F_MDR,
        ST_F_CIR,
        ST_EXEC,
        ST_PTR_RD,
        ST_PTR_WT,
        ST_OPD_RD,
        ST_OPD_WT,
        ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        K_LD_DIR,
        K_STORE,
        K_LD_IND,
        K_LD_IDX,
        K_INCR,
        K_JUMP,
        K_SET_IX,
        K_STOP
    } kind_e;

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
    import acc_core_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output kind_e            kind_o
);

    always_comb begin
        unique case (opc_i)
            OPC_LD_DIR: kind_o = K_LD_DIR;
            OPC_STORE:  kind_o = K_STORE;
            OPC_LD_IND: kind_o = K_LD_IND;
            OPC_LD_IDX: kind_o = K_LD_IDX;
            OPC_INCR:   kind_o = K_INCR;
            OPC_JUMP:   kind_o = K_JUMP;
            OPC_SET_IX: kind_o = K_SET_IX;
            default:    kind_o = K_STOP;   // stop opcode and all undefined codes
        endcase
    end

endmodule

// File: rtl/acc_core_agen.sv
module acc_core_agen #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] idx_i,
    input  logic              use_idx_i,
    output logic [ADDR_W-1:0] ea_o
);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = use_idx_i ? idx_i : '0;
        ea_o   = base_i + offset;   // wraps modulo 2^ADDR_W
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic [DATA_W-1:0] acc_out,
    output logic [ADDR_W-1:0] pc_out
);

    localparam int OPC_LSB = DATA_W - OPC_W;

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [ADDR_W-1:0] idx;
        logic [DATA_W-1:0] mdr;
        logic [DATA_W-1:0] cir;
        logic [DATA_W-1:0] acc;
    } core_t;

    core_t q, d;

    logic [OPC_W-1:0]  opc;
    logic [ADDR_W-1:0] operand;
    logic [ADDR_W-1:0] ea;
    kind_e             kind;

    assign opc     = q.cir[DATA_W-1:OPC_LSB];
    assign operand = q.cir[ADDR_W-1:0];

    acc_core_decode u_dec (
        .opc_i  (opc),
        .kind_o (kind)
    );

    acc_core_agen #(.ADDR_W(ADDR_W)) u_agen (
        .base_i    (operand),
        .idx_i     (q.idx),
        .use_idx_i (kind == K_LD_IDX),
        .ea_o      (ea)
    );

    always_comb begin
        d         = q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = q.mar;
        mem_wdata = q.acc;
        unique case (q.st)
            ST_F_MAR: begin
                d.mar = q.pc;
                d.st  = ST_F_INC;
            end
            ST_F_INC: begin
                d.pc   = q.pc + 1'b1;
                mem_rd = 1'b1;
                d.st   = ST_F_MDR;
            end
            ST_F_MDR: begin
                d.mdr = mem_rdata;
                d.st  = ST_F_CIR;
            end
            ST_F_CIR: begin
                d.cir = q.mdr;
                d.st  = ST_EXEC;
            end
            ST_EXEC: begin
                d.st = ST_F_MAR;
                unique case (kind)
                    K_LD_DIR, K_LD_IDX: begin
                        d.mar = ea;
                        d.st  = ST_OPD_RD;
                    end
                    K_LD_IND: begin
                        d.mar = operand;
                        d.st  = ST_PTR_RD;
                    end
                    K_STORE: begin
                        mem_wr   = 1'b1;
                        mem_addr = operand;
                    end
                    K_INCR:   d.acc = q.acc + 1'b1;
                    K_JUMP:   d.pc  = operand;
                    K_SET_IX: d.idx = operand;
                    default:  d.st  = ST_HALT;
                endcase
            end
            ST_PTR_RD: begin
                mem_rd = 1'b1;
                d.st   = ST_PTR_WT;
            end
            ST_PTR_WT: begin
                d.mdr = mem_rdata;
                d.mar = mem_rdata[ADDR_W-1:0];
                d.st  = ST_OPD_RD;
            end
            ST_OPD_RD: begin
                mem_rd = 1'b1;
                d.st   = ST_OPD_WT;
            end
            ST_OPD_WT: begin
                d.mdr = mem_rdata;
                d.acc = mem_rdata;
                d.st  = ST_F_MAR;
            end
            ST_HALT: d.st = ST_HALT;
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign halted  = (q.st == ST_HALT);
    assign acc_out = q.acc;
    assign pc_out  = q.pc;

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_F_INC) |-> (mem_rd && mem_addr == q.pc));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_F_INC) |=> ((q.pc - $past(q.pc)) == ADDR_W'(1)));

    // R8
    incr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && kind == K_INCR) |=> ((q.acc - $past(q.acc)) == DATA_W'(1)));

    // R5
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (!mem_rd && mem_wdata == q.acc && q.st == ST_EXEC));

    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_OPD_WT) |=> (q.acc == $past(mem_rdata)));

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(q.pc) && $stable(q.acc)));

endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;

    localparam int AW    = 8;
    localparam int DW    = 12;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          halted;
    logic [DW-1:0] acc_out;
    logic [AW-1:0] pc_out;

    always #5 clk = ~clk;

    acc_core #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .acc_out   (acc_out),
        .pc_out    (pc_out)
    );

    logic [DW-1:0] img [DEPTH];
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_log [8];
    int            n_rd;
    int            n_wr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= img[i];
            n_rd <= 0;
            n_wr <= 0;
        end else begin
            if (mem_rd) begin
                mem_rdata <= mem[mem_addr];
                if (n_rd < 8) rd_log[n_rd] <= mem_addr;
                n_rd <= n_rd + 1;
            end
            if (mem_wr) begin
                mem[mem_addr] <= mem_wdata;
                n_wr <= n_wr + 1;
            end
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ins(int op, int opd);
        return {op[3:0], opd[AW-1:0]};
    endfunction

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 37 + 5);
    endfunction

    task automatic clear_img();
        for (int i = 0; i < DEPTH; i++) img[i] = '0;
    endtask

    task automatic fill_img();
        for (int i = 0; i < DEPTH; i++) img[i] = pat(i);
    endtask

    task automatic boot();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(output int cyc);
        cyc = 0;
        while (!halted && cyc < 4000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        int rd0;
        int wr0;

        // R1 reset state, then R11/R12 on an all-zero memory (opcode 0)
        clear_img();
        boot();
        chk("R1 pc after reset", pc_out, 0);
        chk("R1 acc after reset", acc_out, 0);
        chk("R1 halted after reset", halted, 0);
        run(cyc);
        chk("R12 cycles for undefined opcode", cyc, 5);
        chk("R11 halted on opcode 0", halted, 1);
        chk("R11 pc after opcode 0", pc_out, 1);

        // R4 R5 R6 R8 R12: increment a cell in memory, then indirect load
        clear_img();
        img[0]  = ins(1, 40);
        img[1]  = ins(5, 0);
        img[2]  = ins(2, 40);
        img[3]  = ins(3, 41);
        img[4]  = ins(5, 0);
        img[5]  = ins(2, 42);
        img[6]  = ins(7, 0);
        img[40] = 49;
        img[41] = 43;
        img[43] = 36;
        boot();
        run(cyc);
        chk("R12 program cycle total", cyc, 41);
        chk("R5 incremented cell", mem[40], 50);
        chk("R6 stored indirect+1", mem[42], 37);
        chk("R4 acc final", acc_out, 37);
        chk("R11 halted after stop", halted, 1);
        chk("R11 pc after stop", pc_out, 7);

        // R7 R10: indexed load over every index value, wrapping the address
        for (int k = 0; k < DEPTH; k++) begin
            logic [AW-1:0] ea;
            fill_img();
            img[0] = ins(8, k);
            img[1] = ins(4, 8'h80);
            img[2] = ins(2, 4);
            img[3] = ins(7, 0);
            ea = AW'(8'h80 + k);
            boot();
            run(cyc);
            chk("R7 indexed load acc", acc_out, img[ea]);
            chk("R10 indexed load stored", mem[4], img[ea]);
            if (k == 0) chk("R12 indexed program cycles", cyc, 22);
        end

        // R8 R3: increment wrap with operands at the top of the address range
        foreach (img[i]) img[i] = '0;
        for (int j = 0; j < 5; j++) begin
            logic [DW-1:0] v;
            case (j)
                0: v = 12'h000;
                1: v = 12'h001;
                2: v = 12'h7FF;
                3: v = 12'hFFE;
                default: v = 12'hFFF;
            endcase
            clear_img();
            img[8'hFE] = v;
            img[0] = ins(1, 8'hFE);
            img[1] = ins(5, 0);
            img[2] = ins(5, 0);
            img[3] = ins(2, 8'hFF);
            img[4] = ins(7, 0);
            boot();
            run(cyc);
            chk("R8 wrapped increment", mem[8'hFF], DW'(v + 2));
            chk("R3 high operand source intact", mem[8'hFE], v);
        end

        // R9 R2: jump, with the fetch addresses observed at the memory port
        clear_img();
        img[0]  = ins(6, 20);
        img[1]  = ins(5, 0);
        img[20] = ins(5, 0);
        img[21] = ins(7, 0);
        boot();
        run(cyc);
        chk("R9 acc after jump", acc_out, 1);
        chk("R9 pc after jump", pc_out, 22);
        chk("R12 jump program cycles", cyc, 15);
        chk("R2 read count", n_rd, 3);
        chk("R2 first fetch address", rd_log[0], 0);
        chk("R2 fetch after jump", rd_log[1], 20);
        chk("R2 sequential fetch", rd_log[2], 21);

        // R6: indirect load, pointer words with nonzero upper bits
        for (int p = 0; p < 16; p++) begin
            logic [AW-1:0] ptr;
            ptr = AW'(8'h60 + p * 11);
            fill_img();
            img[0]     = ins(3, 8'h50);
            img[1]     = ins(2, 8'h51);
            img[2]     = ins(7, 0);
            img[8'h50] = {4'hA, ptr};
            boot();
            run(cyc);
            chk("R6 indirect load", mem[8'h51], img[ptr]);
            if (p == 0) chk("R12 indirect program cycles", cyc, 19);
        end

        // R11: stop opcode and each undefined opcode
        for (int op = 0; op < 16; op++) begin
            if (op == 0 || op == 7 || op >= 9) begin
                clear_img();
                img[0] = ins(5, 0);
                img[1] = ins(op, 5);
                img[2] = ins(5, 0);
                img[5] = ins(5, 0);
                boot();
                run(cyc);
                chk("R11 halted", halted, 1);
                chk("R11 pc at stop", pc_out, 2);
                rd0 = n_rd;
                wr0 = n_wr;
                repeat (20) @(negedge clk);
                chk("R11 pc held", pc_out, 2);
                chk("R11 acc held", acc_out, 1);
                chk("R11 no reads after stop", n_rd, rd0);
                chk("R11 no writes after stop", n_wr, wr0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule